// File: doc/BRIEF.md
# Trimmed Time-Base Prescaler

This block turns a 32768 Hz crystal clock into the 100 Hz update tick that drives a real-time clock's counters. The ratio is not a whole number, so a phase accumulator adds a fixed step on every oscillator cycle and emits a one-cycle tick each time it wraps. This keeps the long-run average at exactly 100 Hz before any correction is applied.

Crystal error is corrected in logic rather than at the oscillator. A fixed correction window of 1,015,808 oscillator cycles (31 seconds) is counted continuously. In the first T cycles of every window, where T is the 8-bit trim value, the accumulator is held, so T input cycles are removed per window. Each step of T slows the tick by about 0.984 ppm, and the largest value removes about 251 ppm.

The trim register can be protected by a lock input. Test inputs speed the tick up 32 times or suspend the correction. A tuning-mode input routes a 20%-duty 100 Hz waveform to the interrupt pin so the uncorrected rate can be measured externally.

Top module: `trim_prescaler`

## Requirements
- R1: Starting from a restart with trim 0 and no test bit set, the number of ticks after E oscillator cycles is floor(E·100/32768).
- R2: The tick is a single-cycle pulse: it is never high in two consecutive cycles.
- R3: A window counter cycles through WIN_CYCLES (default 1,015,808) oscillator cycles. In window positions 0 to T−1, where T is the trim value, the accumulator holds and no tick is issued. The tick count after E cycles is therefore floor(A·100/32768), with A = E − (E div WIN_CYCLES)·T − min(E mod WIN_CYCLES, T).
- R4: Trim value 0 removes no cycles. Trim value 255 removes 255 cycles per window, which is the largest correction.
- R5: A write strobe with the lock input low loads trim_wdata into the trim register at that clock edge. trim_value shows the stored value from the next cycle.
- R6: A write strobe while the lock input is high leaves the trim register unchanged.
- R7: While test_notrim is high, no cycle is removed, whatever the trim value.
- R8: While test_accel is high, the accumulator step is 32 times larger, so the tick count after E cycles is floor(E·3200/32768) with trim 0.
- R9: With tune_mode high, cal_out is high for the first fifth of each tick period (accumulator phase below 32768/5). It is high in every cycle in which the tick is high, giving a 20% duty cycle. With tune_mode low, cal_out is held low.
- R10: The restart input clears the window position and the accumulator phase at the clock edge. The tick is low in the following cycle.
- R11: After asynchronous reset the tick, cal_out and trim_value are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous restart of window and phase |
| trim_we | input | 1 | Trim register write strobe |
| trim_wdata | input | 8 | Trim value to write |
| set_lock | input | 1 | Blocks trim writes when high |
| test_accel | input | 1 | Runs the tick 32 times faster |
| test_notrim | input | 1 | Suspends cycle removal |
| tune_mode | input | 1 | Enables the calibration waveform |
| tick | output | 1 | 100 Hz update tick, one cycle wide |
| cal_out | output | 1 | 20%-duty calibration waveform |
| trim_value | output | 8 | Current trim register contents |

## Verification
A wrong window position or a wrong inhibit span changes how many ticks appear over one window, so an error shows as a tick count off by one or more after a single window of a few thousand cycles. A corrupted accumulator phase shifts the tick and the calibration high period at once, and it is visible within one tick period of about 328 cycles. Errors in the step scaling show up in the 32-fold accelerated mode within a few hundred cycles. Errors in the trim register show at once on its readback port after a write, both with the lock set and with it clear.

// File: rtl/prescale_pkg.sv
`timescale 1ns/1ps
package prescale_pkg;
  localparam int TRIM_W      = 8;
  localparam int ACCEL_SHIFT = 5;
  typedef logic [TRIM_W-1:0] trim_t;
endpackage

// File: rtl/prescale_trim_reg.sv
`timescale 1ns/1ps
// Trim value storage with write protection.
module prescale_trim_reg
  import prescale_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  logic  lock,
  input  trim_t wr_data,
  output trim_t value
);
  trim_t trim_q;
  trim_t trim_d;
  logic  load_en;

  always_comb begin
    load_en = wr_en && !lock;
    trim_d  = trim_q;
    if (load_en) trim_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trim_q <= '0;
    else        trim_q <= trim_d;
  end

  assign value = trim_q;
endmodule

// File: rtl/prescale_window.sv
`timescale 1ns/1ps
// Correction window position and the inhibit span at its start.
module prescale_window
  import prescale_pkg::*;
#(
  parameter int WIN_CYCLES = 1015808
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  logic  bypass,
  input  trim_t trim,
  output logic  inhibit
);
  localparam int CNT_W = $clog2(WIN_CYCLES);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WIN_CYCLES - 1);

  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] pos_d;
  logic [CNT_W-1:0] trim_ext;

  always_comb begin
    trim_ext = {{(CNT_W-TRIM_W){1'b0}}, trim};
    if (restart)               pos_d = '0;
    else if (pos_q == LAST_POS) pos_d = '0;
    else                       pos_d = pos_q + 1'b1;
    inhibit = !bypass && (pos_q < trim_ext);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end
endmodule

// File: rtl/prescale_fracdiv.sv
`timescale 1ns/1ps
// Phase-accumulator divider producing the tick and the calibration wave.
module prescale_fracdiv
  import prescale_pkg::*;
#(
  parameter int OSC_HZ  = 32768,
  parameter int TICK_HZ = 100,
  parameter int ACC_W   = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  input  logic             accel,
  input  logic             tune,
  output logic             tick,
  output logic             cal,
  output logic [ACC_W-1:0] phase
);
  localparam logic [ACC_W-1:0] MODULUS = ACC_W'(OSC_HZ);
  localparam logic [ACC_W-1:0] STEP_N  = ACC_W'(TICK_HZ);
  localparam logic [ACC_W-1:0] STEP_A  = ACC_W'(TICK_HZ << ACCEL_SHIFT);
  localparam logic [ACC_W-1:0] DUTY    = ACC_W'(OSC_HZ / 5);

  logic [ACC_W-1:0] acc_q, acc_d, sum;
  logic             tick_q, tick_d, wrap;

  always_comb begin
    sum    = acc_q + (accel ? STEP_A : STEP_N);
    wrap   = (sum >= MODULUS);
    acc_d  = acc_q;
    tick_d = 1'b0;
    if (restart) begin
      acc_d = '0;
    end else if (advance) begin
      acc_d  = wrap ? (sum - MODULUS) : sum;
      tick_d = wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign tick  = tick_q;
  assign cal   = tune && (acc_q < DUTY);
  assign phase = acc_q;
endmodule

// File: rtl/trim_prescaler.sv
`timescale 1ns/1ps
module trim_prescaler
  import prescale_pkg::*;
#(
  parameter int OSC_HZ     = 32768,
  parameter int TICK_HZ    = 100,
  parameter int WIN_CYCLES = 1015808
) (
  input  logic       clk_osc,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       trim_we,
  input  logic [7:0] trim_wdata,
  input  logic       set_lock,
  input  logic       test_accel,
  input  logic       test_notrim,
  input  logic       tune_mode,
  output logic       tick,
  output logic       cal_out,
  output logic [7:0] trim_value
);
  localparam int ACC_W = $clog2(OSC_HZ + (TICK_HZ << ACCEL_SHIFT)) + 1;

  trim_t            trim_cur;
  logic             inhibit;
  logic             advance;
  logic [ACC_W-1:0] phase;

  prescale_trim_reg u_trim (
    .clk(clk_osc), .rst_n(rst_n), .wr_en(trim_we), .lock(set_lock),
    .wr_data(trim_wdata), .value(trim_cur)
  );

  prescale_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
    .clk(clk_osc), .rst_n(rst_n), .restart(restart), .bypass(test_notrim),
    .trim(trim_cur), .inhibit(inhibit)
  );

  assign advance = !inhibit;

  prescale_fracdiv #(.OSC_HZ(OSC_HZ), .TICK_HZ(TICK_HZ), .ACC_W(ACC_W)) u_div (
    .clk(clk_osc), .rst_n(rst_n), .restart(restart), .advance(advance),
    .accel(test_accel), .tune(tune_mode), .tick(tick), .cal(cal_out),
    .phase(phase)
  );

  assign trim_value = trim_cur;
endmodule

// File: rtl/trim_prescaler_chk.sv
`timescale 1ns/1ps
module trim_prescaler_chk #(
  parameter int ACC_W = 17
) (
  input logic             clk_osc,
  input logic             rst_n,
  input logic             restart,
  input logic             trim_we,
  input logic [7:0]       trim_wdata,
  input logic             set_lock,
  input logic             tune_mode,
  input logic             tick,
  input logic             cal_out,
  input logic [7:0]       trim_value,
  input logic             inhibit,
  input logic [ACC_W-1:0] phase
);
  assert_trim_load_R5: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (trim_we && !set_lock) |=> (trim_value == $past(trim_wdata)));

  assert_lock_hold_R6: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (trim_we && set_lock) |=> $stable(trim_value));

  assert_single_tick_R2: assert property (@(posedge clk_osc) disable iff (!rst_n)
    tick |=> !tick);

  assert_cal_on_tick_R9: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (tune_mode && tick) |-> cal_out);

  assert_restart_clear_R10: assert property (@(posedge clk_osc) disable iff (!rst_n)
    restart |=> (!tick && phase == '0));

  assert_inhibit_hold_R3: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (inhibit && !restart) |=> ($stable(phase) && !tick));
endmodule

bind trim_prescaler trim_prescaler_chk #(.ACC_W(ACC_W)) u_chk (
  .clk_osc(clk_osc), .rst_n(rst_n), .restart(restart), .trim_we(trim_we),
  .trim_wdata(trim_wdata), .set_lock(set_lock), .tune_mode(tune_mode),
  .tick(tick), .cal_out(cal_out), .trim_value(trim_value),
  .inhibit(inhibit), .phase(phase)
);

// File: tb/trim_prescaler_test.sv
`timescale 1ns/1ps
module trim_prescaler_test;
  localparam int OSC = 32768;
  localparam int HZ  = 100;
  localparam int WIN = 2000;

  logic clk_osc = 1'b0;
  logic rst_n, restart, trim_we, set_lock, test_accel, test_notrim, tune_mode;
  logic [7:0] trim_wdata;
  logic tick, cal_out;
  logic [7:0] trim_value;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_osc = ~clk_osc;

  trim_prescaler #(.OSC_HZ(OSC), .TICK_HZ(HZ), .WIN_CYCLES(WIN)) uut (
    .clk_osc(clk_osc), .rst_n(rst_n), .restart(restart), .trim_we(trim_we),
    .trim_wdata(trim_wdata), .set_lock(set_lock), .test_accel(test_accel),
    .test_notrim(test_notrim), .tune_mode(tune_mode), .tick(tick),
    .cal_out(cal_out), .trim_value(trim_value)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint exp_ticks(input longint e, input longint t, input longint step);
    longint rem, inh;
    rem = e % WIN;
    inh = (e / WIN) * t + ((rem < t) ? rem : t);
    return ((e - inh) * step) / OSC;
  endfunction

  task automatic do_restart();
    @(negedge clk_osc) restart = 1'b1;
    @(posedge clk_osc);
    @(negedge clk_osc) restart = 1'b0;
  endtask

  task automatic write_trim(input logic [7:0] v);
    @(negedge clk_osc) begin trim_we = 1'b1; trim_wdata = v; end
    @(posedge clk_osc);
    @(negedge clk_osc) trim_we = 1'b0;
  endtask

  task automatic run(input int n, output int ticks, output int cals,
                     output int dbl, output int miss);
    logic prev;
    prev = 1'b0; ticks = 0; cals = 0; dbl = 0; miss = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk_osc);
      @(negedge clk_osc);
      if (tick) ticks++;
      if (cal_out) cals++;
      if (tick && prev) dbl++;
      if (tick && tune_mode && !cal_out) miss++;
      prev = tick;
    end
  endtask

  task automatic t_reset();
    check("R11 tick", tick, 0);
    check("R11 cal_out", cal_out, 0);
    check("R11 trim_value", trim_value, 0);
  endtask

  task automatic t_plain();
    int tk, cl, db, ms;
    do_restart();
    check("R10 tick after restart", tick, 0);
    run(20000, tk, cl, db, ms);
    check("R1 untrimmed ticks", tk, exp_ticks(20000, 0, HZ));
    check("R2 no double tick", db, 0);
    check("R9 cal low when tune off", cl, 0);
  endtask

  task automatic t_trim();
    int tk, cl, db, ms;
    write_trim(8'd200);
    check("R5 trim loaded", trim_value, 200);
    do_restart();
    run(20000, tk, cl, db, ms);
    check("R3 trimmed ticks", tk, exp_ticks(20000, 200, HZ));
  endtask

  task automatic t_lock();
    set_lock = 1'b1;
    write_trim(8'd17);
    check("R6 locked write ignored", trim_value, 200);
    set_lock = 1'b0;
  endtask

  task automatic t_notrim();
    int tk, cl, db, ms;
    test_notrim = 1'b1;
    do_restart();
    run(20000, tk, cl, db, ms);
    check("R7 notrim ticks", tk, exp_ticks(20000, 0, HZ));
    test_notrim = 1'b0;
  endtask

  task automatic t_limits();
    int tk, cl, db, ms;
    write_trim(8'd255);
    do_restart();
    run(20000, tk, cl, db, ms);
    check("R4 max trim ticks", tk, exp_ticks(20000, 255, HZ));
    write_trim(8'd0);
    do_restart();
    run(20000, tk, cl, db, ms);
    check("R4 zero trim ticks", tk, exp_ticks(20000, 0, HZ));
  endtask

  task automatic t_accel();
    int tk, cl, db, ms;
    test_accel = 1'b1;
    do_restart();
    run(3000, tk, cl, db, ms);
    check("R8 accelerated ticks", tk, exp_ticks(3000, 0, HZ * 32));
    check("R2 no double tick accel", db, 0);
    test_accel = 1'b0;
  endtask

  task automatic t_cal();
    int tk, cl, db, ms;
    tune_mode = 1'b1;
    do_restart();
    run(20000, tk, cl, db, ms);
    check("R9 cal high on tick", ms, 0);
    check("R9 duty near 20%", (cl >= 3900 && cl <= 4100), 1);
    tune_mode = 1'b0;
    run(500, tk, cl, db, ms);
    check("R9 cal low after tune off", cl, 0);
  endtask

  initial begin
    rst_n = 1'b0; restart = 1'b0; trim_we = 1'b0; trim_wdata = '0;
    set_lock = 1'b0; test_accel = 1'b0; test_notrim = 1'b0; tune_mode = 1'b0;
    repeat (3) @(negedge clk_osc);
    t_reset();
    rst_n = 1'b1;
    t_plain();
    t_trim();
    t_lock();
    t_notrim();
    t_limits();
    t_accel();
    t_cal();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule